// File: doc/BRIEF.md
# Range Checksum and CRC Engine

This engine reduces a contiguous stretch of byte memory to one 16-bit digest. After a start pulse it reads each byte from a first address up to a last address, in ascending order and including both ends. It folds every byte into a running value. That value is either an additive sum or a CRC, depending on a mode input sampled at start. The seed and the CRC polynomial are run-time inputs. The usual setting is a zero seed with polynomial 0x1021.

The engine drives a memory port with one cycle of read latency and a byte write strobe. When storing is enabled, it writes the final digest back into the same memory after the scan. Completion is signalled by a one-cycle done pulse. The result and a range-error flag stay on their outputs until the next accepted start. Command parsing and configuration storage sit outside the block, in the logic that drives its inputs.

Top module: `range_digest`

## Requirements
- R1: In sum mode (`crc_mode_i` = 0), the result is the seed plus every byte in the range, each zero-extended to 16 bits, taken modulo 2^16.
- R2: In CRC mode (`crc_mode_i` = 1), the value starts from the seed. For each byte, the byte is XORed into bits 15:8. The value then takes eight MSB-first shifts, and each shift XORs the polynomial in when the bit shifted out was 1. The CRC is not reflected and has no final XOR.
- R3: Each address from `first_addr_i` to `last_addr_i` inclusive is read exactly once, in ascending order. Equal first and last addresses read one byte. No write happens while reads are in progress.
- R4: With `store_en_i` = 1, after the last read the result's bits 15:8 are written at `dest_addr_i` and bits 7:0 at `dest_addr_i` + 1. The second address wraps modulo 2^ADDR_W.
- R5: With `store_en_i` = 0, the engine writes nothing to memory.
- R6: If `first_addr_i` is greater than `last_addr_i`, `range_err_o` is 1 when done pulses, the result equals the seed, and no memory read or write takes place.
- R7: `done_o` is high for exactly one cycle per accepted start. `result_o` and `range_err_o` hold their values until the next accepted start.
- R8: A start pulse while `busy_o` is 1 is ignored, and the input values present with it have no effect on the running operation or its result.
- R9: After reset, `busy_o`, `done_o`, `range_err_o`, `mem_rd_o` and `mem_wr_o` are 0 and `result_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| crc_mode_i | input | 1 | 0 = additive sum, 1 = CRC |
| first_addr_i | input | ADDR_W | First byte address of the range |
| last_addr_i | input | ADDR_W | Last byte address of the range (inclusive) |
| dest_addr_i | input | ADDR_W | Address that receives the high result byte |
| store_en_i | input | 1 | Write the result back when 1 |
| seed_i | input | 16 | Initial digest value |
| poly_i | input | 16 | CRC polynomial |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_rd_o | output | 1 | Read strobe; data is returned one cycle later |
| mem_rdata_i | input | 8 | Read data |
| mem_wr_o | output | 1 | Write strobe |
| mem_wdata_o | output | 8 | Write data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| range_err_o | output | 1 | Last start had first address greater than last address |
| result_o | output | 16 | Final digest |

## Verification
The bench builds the engine with ADDR_W = 10, so its 1 KiB memory model covers the whole address space. With that width, a scan that ends on the topmost address can be run. A store whose low byte wraps to address 0 can also be run. The CRC checks include the known check values for the text "123456789": 0x31C3 with seed 0 and 0x29B1 with seed 0xFFFF. They also use a second polynomial with a non-zero seed, and sum runs long enough for the 16-bit total to wrap.

// File: rtl/range_digest_pkg.sv
package range_digest_pkg;
  localparam int DIGEST_W = 16;
  localparam int BYTE_W   = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCAN,
    ST_DRAIN,
    ST_PUT_HI,
    ST_PUT_LO,
    ST_FINISH
  } walk_state_t;
endpackage

// File: rtl/range_digest_crc_step.sv
module range_digest_crc_step #(
  parameter int W = 16,
  parameter int B = 8
) (
  input  logic [W-1:0] crc_i,
  input  logic [B-1:0] byte_i,
  input  logic [W-1:0] poly_i,
  output logic [W-1:0] crc_o
);
  localparam int PAD = W - B;

  logic [B:0][W-1:0] stage;

  assign stage[0] = crc_i ^ {byte_i, {PAD{1'b0}}};

  // One XOR-shift stage per input bit, most significant bit first
  for (genvar g = 0; g < B; g++) begin : g_bit
    assign stage[g+1] = stage[g][W-1] ? ((stage[g] << 1) ^ poly_i)
                                      : (stage[g] << 1);
  end

  assign crc_o = stage[B];
endmodule

// File: rtl/range_digest_acc.sv
module range_digest_acc
  import range_digest_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                load_i,
  input  logic [DIGEST_W-1:0] seed_i,
  input  logic                step_i,
  input  logic                crc_mode_i,
  input  logic [BYTE_W-1:0]   byte_i,
  input  logic [DIGEST_W-1:0] poly_i,
  output logic [DIGEST_W-1:0] acc_o
);
  localparam int EXT = DIGEST_W - BYTE_W;

  logic [DIGEST_W-1:0] crc_next;
  logic [DIGEST_W-1:0] sum_next;

  range_digest_crc_step #(.W(DIGEST_W), .B(BYTE_W)) i_step (
    .crc_i  (acc_o),
    .byte_i (byte_i),
    .poly_i (poly_i),
    .crc_o  (crc_next)
  );

  assign sum_next = acc_o + {{EXT{1'b0}}, byte_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_o <= '0;
    end else if (load_i) begin
      acc_o <= seed_i;
    end else if (step_i) begin
      acc_o <= crc_mode_i ? crc_next : sum_next;
    end
  end

  // R2/R1: the running value only moves on a load or a byte step
  assert_acc_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !step_i) |=> $stable(acc_o));
endmodule

// File: rtl/range_digest_ctrl.sv
module range_digest_ctrl
  import range_digest_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic                crc_mode_i,
  input  logic [ADDR_W-1:0]   first_addr_i,
  input  logic [ADDR_W-1:0]   last_addr_i,
  input  logic [ADDR_W-1:0]   dest_addr_i,
  input  logic                store_en_i,
  input  logic [DIGEST_W-1:0] poly_i,
  input  logic [DIGEST_W-1:0] acc_i,
  output logic                acc_load_o,
  output logic                acc_step_o,
  output logic                mode_q_o,
  output logic [DIGEST_W-1:0] poly_q_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic                mem_rd_o,
  output logic                mem_wr_o,
  output logic [BYTE_W-1:0]   mem_wdata_o,
  output logic                busy_o,
  output logic                done_o,
  output logic                range_err_o,
  output logic [DIGEST_W-1:0] result_o
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  walk_state_t       state;
  logic [ADDR_W-1:0] first_q;
  logic [ADDR_W-1:0] last_q;
  logic [ADDR_W-1:0] dest_q;
  logic              store_q;
  logic              rvalid_q;
  logic              accept;

  assign accept     = (state == ST_IDLE) && start_i;
  assign acc_load_o = accept;
  assign acc_step_o = rvalid_q;
  assign busy_o     = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      first_q     <= '0;
      last_q      <= '0;
      dest_q      <= '0;
      store_q     <= 1'b0;
      mode_q_o    <= 1'b0;
      poly_q_o    <= '0;
      rvalid_q    <= 1'b0;
      mem_addr_o  <= '0;
      mem_rd_o    <= 1'b0;
      mem_wr_o    <= 1'b0;
      mem_wdata_o <= '0;
      done_o      <= 1'b0;
      range_err_o <= 1'b0;
      result_o    <= '0;
    end else begin
      done_o   <= 1'b0;
      rvalid_q <= mem_rd_o;
      case (state)
        ST_IDLE: begin
          if (start_i) begin
            first_q     <= first_addr_i;
            last_q      <= last_addr_i;
            dest_q      <= dest_addr_i;
            store_q     <= store_en_i;
            mode_q_o    <= crc_mode_i;
            poly_q_o    <= poly_i;
            range_err_o <= 1'b0;
            if (first_addr_i > last_addr_i) begin
              range_err_o <= 1'b1;
              state       <= ST_FINISH;
            end else begin
              mem_addr_o <= first_addr_i;
              mem_rd_o   <= 1'b1;
              state      <= ST_SCAN;
            end
          end
        end
        ST_SCAN: begin
          if (mem_addr_o == last_q) begin
            mem_rd_o <= 1'b0;
            state    <= ST_DRAIN;
          end else begin
            mem_addr_o <= mem_addr_o + ONE;
          end
        end
        ST_DRAIN: begin
          // the final byte is folded in on this edge
          state <= store_q ? ST_PUT_HI : ST_FINISH;
        end
        ST_PUT_HI: begin
          mem_wr_o    <= 1'b1;
          mem_addr_o  <= dest_q;
          mem_wdata_o <= acc_i[DIGEST_W-1:BYTE_W];
          state       <= ST_PUT_LO;
        end
        ST_PUT_LO: begin
          mem_addr_o  <= dest_q + ONE;
          mem_wdata_o <= acc_i[BYTE_W-1:0];
          state       <= ST_FINISH;
        end
        ST_FINISH: begin
          mem_wr_o <= 1'b0;
          done_o   <= 1'b1;
          result_o <= acc_i;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_result_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(result_o));

  assert_read_inside_R3: assert property (@(posedge clk) disable iff (rst)
    mem_rd_o |-> (mem_addr_o >= first_q && mem_addr_o <= last_q));

  assert_read_ascend_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_o && $past(mem_rd_o)) |-> (mem_addr_o == $past(mem_addr_o) + ONE));

  assert_no_rw_overlap_R3: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_o && mem_wr_o));

  assert_write_target_R4: assert property (@(posedge clk) disable iff (rst)
    mem_wr_o |-> (mem_addr_o == dest_q || mem_addr_o == dest_q + ONE));

  assert_no_store_R5: assert property (@(posedge clk) disable iff (rst)
    !store_q |-> !mem_wr_o);

  assert_err_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    range_err_o |-> (!mem_rd_o && !mem_wr_o));

  assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i) |=> ($stable(first_q) && $stable(last_q) && $stable(mode_q_o)));
endmodule

// File: rtl/range_digest.sv
module range_digest
  import range_digest_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic                crc_mode_i,
  input  logic [ADDR_W-1:0]   first_addr_i,
  input  logic [ADDR_W-1:0]   last_addr_i,
  input  logic [ADDR_W-1:0]   dest_addr_i,
  input  logic                store_en_i,
  input  logic [15:0]         seed_i,
  input  logic [15:0]         poly_i,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic                mem_rd_o,
  input  logic [7:0]          mem_rdata_i,
  output logic                mem_wr_o,
  output logic [7:0]          mem_wdata_o,
  output logic                busy_o,
  output logic                done_o,
  output logic                range_err_o,
  output logic [15:0]         result_o
);
  logic                acc_load;
  logic                acc_step;
  logic                mode_q;
  logic [DIGEST_W-1:0] poly_q;
  logic [DIGEST_W-1:0] acc;

  range_digest_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .crc_mode_i   (crc_mode_i),
    .first_addr_i (first_addr_i),
    .last_addr_i  (last_addr_i),
    .dest_addr_i  (dest_addr_i),
    .store_en_i   (store_en_i),
    .poly_i       (poly_i),
    .acc_i        (acc),
    .acc_load_o   (acc_load),
    .acc_step_o   (acc_step),
    .mode_q_o     (mode_q),
    .poly_q_o     (poly_q),
    .mem_addr_o   (mem_addr_o),
    .mem_rd_o     (mem_rd_o),
    .mem_wr_o     (mem_wr_o),
    .mem_wdata_o  (mem_wdata_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .range_err_o  (range_err_o),
    .result_o     (result_o)
  );

  range_digest_acc i_acc (
    .clk        (clk),
    .rst        (rst),
    .load_i     (acc_load),
    .seed_i     (seed_i),
    .step_i     (acc_step),
    .crc_mode_i (mode_q),
    .byte_i     (mem_rdata_i),
    .poly_i     (poly_q),
    .acc_o      (acc)
  );

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);
endmodule

// File: tb/test_range_digest.sv
module test_range_digest;
  localparam int AW    = 10;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst;
  logic          start_i;
  logic          crc_mode_i;
  logic [AW-1:0] first_addr_i, last_addr_i, dest_addr_i;
  logic          store_en_i;
  logic [15:0]   seed_i, poly_i;
  logic [AW-1:0] mem_addr_o;
  logic          mem_rd_o, mem_wr_o;
  logic [7:0]    mem_rdata_i, mem_wdata_o;
  logic          busy_o, done_o, range_err_o;
  logic [15:0]   result_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  logic [7:0] mem  [DEPTH];
  logic [7:0] snap [DEPTH];

  int rd_cnt, wr_cnt, rd_min, rd_max, rd_order_bad, prev_rd;

  always #5 clk = ~clk;

  range_digest #(.ADDR_W(AW)) i_range_digest (.*);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (mem_rd_o) mem_rdata_i <= mem[mem_addr_o];
    if (mem_wr_o) mem[mem_addr_o] <= mem_wdata_o;
  end

  always @(negedge clk) begin
    if (mem_rd_o) begin
      if (prev_rd >= 0 && int'(mem_addr_o) != prev_rd + 1) rd_order_bad++;
      prev_rd = int'(mem_addr_o);
      rd_cnt++;
      if (int'(mem_addr_o) < rd_min) rd_min = int'(mem_addr_o);
      if (int'(mem_addr_o) > rd_max) rd_max = int'(mem_addr_o);
    end
    if (mem_wr_o) wr_cnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_sum(int a, int b, logic [15:0] s);
    for (int i = a; i <= b; i++) s = s + {8'h00, snap[i]};
    return s;
  endfunction

  function automatic logic [15:0] ref_crc(int a, int b, logic [15:0] s, logic [15:0] p);
    for (int i = a; i <= b; i++) begin
      s = s ^ {snap[i], 8'h00};
      for (int k = 0; k < 8; k++) s = s[15] ? ((s << 1) ^ p) : (s << 1);
    end
    return s;
  endfunction

  task automatic take_snap();
    for (int i = 0; i < DEPTH; i++) snap[i] = mem[i];
  endtask

  // Issue one start and wait for done; checks the pulse width (R7)
  task automatic run(input bit m, input int a, input int b, input int d,
                     input bit st, input logic [15:0] s, input logic [15:0] p);
    int n;
    take_snap();
    rd_cnt = 0; wr_cnt = 0; rd_min = DEPTH; rd_max = -1; rd_order_bad = 0; prev_rd = -1;
    @(negedge clk);
    crc_mode_i = m; first_addr_i = AW'(a); last_addr_i = AW'(b);
    dest_addr_i = AW'(d); store_en_i = st; seed_i = s; poly_i = p;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    n = 0;
    while (!done_o && n < 4000) begin
      @(negedge clk);
      n++;
    end
    chk(done_o, "R7 done seen", done_o, 1);
    @(negedge clk);
    chk(!done_o, "R7 done one cycle", done_o, 0);
  endtask

  task automatic t_reset();
    chk(!busy_o && !done_o && !range_err_o, "R9 flags", {busy_o, done_o, range_err_o}, 0);
    chk(!mem_rd_o && !mem_wr_o, "R9 strobes", {mem_rd_o, mem_wr_o}, 0);
    chk(result_o == 16'h0, "R9 result", result_o, 0);
  endtask

  task automatic t_crc_known();
    string txt = "123456789";
    for (int i = 0; i < 9; i++) mem[64 + i] = txt[i];
    run(1'b1, 64, 72, 0, 1'b0, 16'h0000, 16'h1021);
    chk(result_o == 16'h31C3, "R2 crc seed0", result_o, 16'h31C3);
    chk(wr_cnt == 0, "R5 no write", wr_cnt, 0);
    run(1'b1, 64, 72, 0, 1'b0, 16'hFFFF, 16'h1021);
    chk(result_o == 16'h29B1, "R2 crc seedFFFF", result_o, 16'h29B1);
  endtask

  task automatic t_crc_poly();
    logic [15:0] e;
    take_snap();
    e = ref_crc(100, 180, 16'h1234, 16'h8005);
    run(1'b1, 100, 180, 0, 1'b0, 16'h1234, 16'h8005);
    chk(result_o == e, "R2 crc poly8005", result_o, e);
    chk(rd_cnt == 81 && rd_min == 100 && rd_max == 180 && rd_order_bad == 0,
        "R3 reads once ascending", rd_cnt, 81);
  endtask

  task automatic t_sum_wrap();
    logic [15:0] e;
    for (int i = 200; i < 456; i++) mem[i] = 8'hFF;
    take_snap();
    e = ref_sum(200, 455, 16'hFFF0);
    run(1'b0, 200, 455, 0, 1'b0, 16'hFFF0, 16'h1021);
    chk(result_o == e, "R1 sum wrap", result_o, e);
    chk(rd_cnt == 256, "R3 count", rd_cnt, 256);
  endtask

  task automatic t_store();
    logic [15:0] e;
    take_snap();
    e = ref_sum(10, 40, 16'h0007);
    run(1'b0, 10, 40, 500, 1'b1, 16'h0007, 16'h1021);
    chk(result_o == e, "R1 sum", result_o, e);
    chk(mem[500] == e[15:8], "R4 high byte", mem[500], e[15:8]);
    chk(mem[501] == e[7:0], "R4 low byte", mem[501], e[7:0]);
    chk(wr_cnt == 2, "R4 two writes", wr_cnt, 2);
    repeat (7) @(negedge clk);
    chk(result_o == e && !range_err_o, "R7 hold", result_o, e);
  endtask

  task automatic t_top_wrap();
    logic [15:0] e;
    take_snap();
    e = ref_crc(DEPTH - 5, DEPTH - 1, 16'hBEEF, 16'h1021);
    run(1'b1, DEPTH - 5, DEPTH - 1, DEPTH - 1, 1'b1, 16'hBEEF, 16'h1021);
    chk(result_o == e, "R2 crc top", result_o, e);
    chk(mem[DEPTH - 1] == e[15:8], "R4 high at top", mem[DEPTH - 1], e[15:8]);
    chk(mem[0] == e[7:0], "R4 low wraps", mem[0], e[7:0]);
  endtask

  task automatic t_single();
    logic [15:0] e;
    mem[300] = 8'hA5;
    take_snap();
    e = 16'h0100 + 16'h00A5;
    run(1'b0, 300, 300, 0, 1'b0, 16'h0100, 16'h1021);
    chk(result_o == e, "R3 single byte", result_o, e);
    chk(rd_cnt == 1, "R3 single read", rd_cnt, 1);
  endtask

  task automatic t_err();
    run(1'b0, 50, 49, 600, 1'b1, 16'h5A5A, 16'h1021);
    chk(range_err_o, "R6 err flag", range_err_o, 1);
    chk(result_o == 16'h5A5A, "R6 result seed", result_o, 16'h5A5A);
    chk(rd_cnt == 0 && wr_cnt == 0, "R6 no access", rd_cnt + wr_cnt, 0);
    chk(mem[600] == snap[600] && mem[601] == snap[601], "R6 mem intact", mem[600], snap[600]);
  endtask

  task automatic t_busy_start();
    logic [15:0] e;
    int n;
    take_snap();
    e = ref_sum(0, 511, 16'h0000);
    rd_cnt = 0; wr_cnt = 0; rd_min = DEPTH; rd_max = -1; rd_order_bad = 0; prev_rd = -1;
    @(negedge clk);
    crc_mode_i = 1'b0; first_addr_i = 0; last_addr_i = 511; dest_addr_i = 0;
    store_en_i = 1'b0; seed_i = 0; poly_i = 16'h1021; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (5) @(negedge clk);
    crc_mode_i = 1'b1; first_addr_i = 700; last_addr_i = 710; store_en_i = 1'b1;
    seed_i = 16'hFFFF; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    n = 0;
    while (!done_o && n < 4000) begin
      @(negedge clk);
      n++;
    end
    chk(result_o == e, "R8 result unaffected", result_o, e);
    chk(wr_cnt == 0 && rd_cnt == 512, "R8 access unaffected", rd_cnt, 512);
    @(negedge clk);
    chk(!done_o && !busy_o, "R8 single done", done_o, 0);
  endtask

  initial begin
    rst = 1'b1; start_i = 1'b0; crc_mode_i = 1'b0; first_addr_i = '0;
    last_addr_i = '0; dest_addr_i = '0; store_en_i = 1'b0; seed_i = '0; poly_i = 16'h1021;
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 3));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_crc_known();
    t_crc_poly();
    t_sum_wrap();
    t_store();
    t_top_wrap();
    t_single();
    t_err();
    t_busy_start();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=0x%0h expected=0x0", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule